// File: doc/BRIEF.md
# Decimal Carry-Save to BCD Converter

This block turns a decimal number held in carry-save form into an ordinary packed BCD number. Each position of the input has a decimal digit in the range 0 to 9 and a single bit of the same weight, so every column is worth 0 to 10. The output is a BCD vector with the same number of positions, 32 by default. The result is neither rounded nor truncated, and a separate bit reports a carry out of the top position. The block is purely combinational. It is the last stage of a decimal multiplier and resolves the redundant sum that leaves the partial-product tree.

For each column, the block first computes two candidate result digits: one for a carry in of zero and one for a carry in of one. Alongside these it forms a propagate flag (the column sum is nine) and a generate flag (the column sum is ten). A logarithmic parallel-prefix network turns these flags into the carry that enters every column. A final multiplexer then picks the matching candidate in each column. No carry enters the bottom column. The carry leaving the top column is the overflow bit, and it stays low for any input that comes from a real product.

Top module: `cs2bcd_conv`

## Requirements
- R1: Digit i of the input sits in bits [4i+3:4i] of `sum_dig`, and its bit sits in bit i of `car_bit`. Digit i of `bcd_out` uses the same slice. The number on `ovf_out` followed by `bcd_out` equals the numeric sum of the digit vector and the bit vector.
- R2: No carry enters position 0, so with all columns below some position summing to at most 9 and none to 10, no carry leaves that range.
- R3: A column whose digit plus bit equals 9 passes its incoming carry upward unchanged, and its output digit is 9 without a carry in and 0 with one.
- R4: A column whose digit plus bit equals 10 always sends a carry to the next position, whatever carry it receives.
- R5: A column whose digit plus bit is at most 8 never sends a carry upward.
- R6: `ovf_out` is the carry out of the top position, and it can be 1 only when the top column sums to 9 or 10.
- R7: With every digit 9, every bit 0 except bit 0 set, the carry ripples the full length: every output digit is 0 and `ovf_out` is 1.
- R8: For input digits in 0..9, every output digit is in 0..9.
- R9: An output digit depends only on the input columns at or below its own position; changing a higher column leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sum_dig | input | NDIG*4 | Carry-save digit vector, one BCD digit per position |
| car_bit | input | NDIG | Carry-save bit vector, one bit per position |
| bcd_out | output | NDIG*4 | Resolved BCD result |
| ovf_out | output | 1 | Carry out of the top position |

## Verification
A wrong carry anywhere in the prefix network shows up as a single output digit that is off by one, or that wraps between 9 and 0. Because the block has no state, the error appears on the output in the same cycle the input is applied. Long runs of propagate columns expose a faulty combine at any prefix distance. The pattern of all nines with one bottom bit forces a carry through every level. A column broken so that it reaches a higher position shows up as a change in a lower digit when only an upper column is altered.

// File: rtl/cs2bcd_pkg.sv
package cs2bcd_pkg;

    typedef logic [3:0] bcd_digit_t;

    localparam bcd_digit_t BCD_MAX = 4'd9;

endpackage

// File: rtl/cs2bcd_column.sv
module cs2bcd_column
    import cs2bcd_pkg::*;
(
    input  bcd_digit_t dig_i,
    input  logic       bit_i,
    output logic       prop_o,
    output logic       gen_o,
    output bcd_digit_t cand0_o,
    output bcd_digit_t cand1_o
);

    logic [4:0] col_sum;
    logic [4:0] col_inc;
    logic [4:0] wrap0;
    logic [4:0] wrap1;

    always_comb begin
        col_sum = {1'b0, dig_i} + {4'b0000, bit_i};
        col_inc = col_sum + 5'd1;
        prop_o  = (col_sum == 5'd9);
        gen_o   = (col_sum == 5'd10);
        wrap0   = (col_sum >= 5'd10) ? (col_sum - 5'd10) : col_sum;
        wrap1   = (col_inc >= 5'd10) ? (col_inc - 5'd10) : col_inc;
        cand0_o = wrap0[3:0];
        cand1_o = wrap1[3:0];
    end

    // R1 R3: the carry-in-one candidate is the successor of the other
    always_comb begin
        if (dig_i <= BCD_MAX) begin
            cand_pair_chk: assert (cand1_o == ((cand0_o == BCD_MAX) ? 4'd0 : cand0_o + 4'd1));
        end
    end

endmodule

// File: rtl/cs2bcd_prefix.sv
module cs2bcd_prefix #(
    parameter int NDIG = 32
) (
    input  logic [NDIG-1:0] gen_i,
    input  logic [NDIG-1:0] prop_i,
    output logic [NDIG-1:0] cin_o,
    output logic            cout_o
);

    localparam int LEVELS = $clog2(NDIG);

    logic [NDIG-1:0] gl [0:LEVELS];
    logic [NDIG-1:0] pl [0:LEVELS];

    assign gl[0] = gen_i;
    assign pl[0] = prop_i;

    for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
        localparam int DIST = 1 << lv;
        for (genvar j = 0; j < NDIG; j++) begin : g_node
            if (j >= DIST) begin : g_comb
                assign gl[lv+1][j] = gl[lv][j] | (pl[lv][j] & gl[lv][j-DIST]);
                assign pl[lv+1][j] = pl[lv][j] & pl[lv][j-DIST];
            end else begin : g_pass
                assign gl[lv+1][j] = gl[lv][j];
                assign pl[lv+1][j] = pl[lv][j];
            end
        end
    end

    assign cin_o  = {gl[LEVELS][NDIG-2:0], 1'b0};
    assign cout_o = gl[LEVELS][NDIG-1];

    for (genvar j = 1; j < NDIG; j++) begin : g_ripple_chk
        // R3 R4 R5: prefix carries agree with the column-by-column recurrence
        always_comb begin
            prefix_ripple_chk: assert (cin_o[j] == (gen_i[j-1] | (prop_i[j-1] & cin_o[j-1])));
        end
    end

    for (genvar j = 0; j < NDIG; j++) begin : g_span_chk
        // R2: an all-propagate span starting at position 0 emits no carry
        always_comb begin
            span_chk: assert (!(pl[LEVELS][j] && gl[LEVELS][j]));
        end
    end

endmodule

// File: rtl/cs2bcd_select.sv
module cs2bcd_select
    import cs2bcd_pkg::*;
#(
    parameter int NDIG = 32
) (
    input  logic [NDIG*4-1:0] cand0_i,
    input  logic [NDIG*4-1:0] cand1_i,
    input  logic [NDIG-1:0]   cin_i,
    output logic [NDIG*4-1:0] bcd_o
);

    for (genvar i = 0; i < NDIG; i++) begin : g_mux
        bcd_digit_t pick;
        assign pick = cin_i[i] ? cand1_i[4*i +: 4] : cand0_i[4*i +: 4];
        assign bcd_o[4*i +: 4] = pick;

        // R8
        always_comb begin
            bcd_range_chk: assert (pick <= BCD_MAX);
        end
    end

endmodule

// File: rtl/cs2bcd_conv.sv
module cs2bcd_conv
    import cs2bcd_pkg::*;
#(
    parameter int NDIG = 32
) (
    input  logic [NDIG*4-1:0] sum_dig,
    input  logic [NDIG-1:0]   car_bit,
    output logic [NDIG*4-1:0] bcd_out,
    output logic              ovf_out
);

    localparam int DW = NDIG * 4;

    logic [NDIG-1:0] prop;
    logic [NDIG-1:0] gen;
    logic [DW-1:0]   cand0;
    logic [DW-1:0]   cand1;
    logic [NDIG-1:0] cin;

    for (genvar i = 0; i < NDIG; i++) begin : g_col
        cs2bcd_column u_col (
            .dig_i   (sum_dig[4*i +: 4]),
            .bit_i   (car_bit[i]),
            .prop_o  (prop[i]),
            .gen_o   (gen[i]),
            .cand0_o (cand0[4*i +: 4]),
            .cand1_o (cand1[4*i +: 4])
        );
    end

    cs2bcd_prefix #(.NDIG(NDIG)) u_prefix (
        .gen_i  (gen),
        .prop_i (prop),
        .cin_o  (cin),
        .cout_o (ovf_out)
    );

    cs2bcd_select #(.NDIG(NDIG)) u_select (
        .cand0_i (cand0),
        .cand1_i (cand1),
        .cin_i   (cin),
        .bcd_o   (bcd_out)
    );

    logic [4:0] top_sum;
    assign top_sum = {1'b0, sum_dig[DW-1 -: 4]} + {4'b0000, car_bit[NDIG-1]};

    // R6
    always_comb begin
        if (ovf_out) begin
            no_overflow_chk: assert (top_sum >= 5'd9);
        end
    end

endmodule

// File: tb/cs2bcd_conv_tb.sv
module cs2bcd_conv_tb;

    localparam int NDIG = 32;
    localparam int DW   = NDIG * 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [DW-1:0]   sum_dig = '0;
    logic [NDIG-1:0] car_bit = '0;
    logic [DW-1:0]   bcd_out;
    logic            ovf_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cs2bcd_conv #(.NDIG(NDIG)) u_dut (
        .sum_dig (sum_dig),
        .car_bit (car_bit),
        .bcd_out (bcd_out),
        .ovf_out (ovf_out)
    );

    function automatic logic [DW:0] ref_sum(input logic [DW-1:0] a, input logic [NDIG-1:0] d);
        logic [DW:0] r;
        int c;
        r = '0;
        c = 0;
        for (int i = 0; i < NDIG; i++) begin
            int t;
            t = int'(a[4*i +: 4]) + int'(d[i]) + c;
            c = (t >= 10) ? 1 : 0;
            r[4*i +: 4] = 4'(t - 10 * c);
        end
        r[DW] = c[0];
        return r;
    endfunction

    task automatic apply_and_check(input logic [DW-1:0] a, input logic [NDIG-1:0] d, input string req);
        logic [DW:0] exp;
        @(posedge clk);
        sum_dig = a;
        car_bit = d;
        exp = ref_sum(a, d);
        @(negedge clk);
        checks++;
        if (bcd_out !== exp[DW-1:0]) begin
            errors++;
            $display("FAIL %s digits: actual %h expected %h", req, bcd_out, exp[DW-1:0]);
        end
        checks++;
        if (ovf_out !== exp[DW]) begin
            errors++;
            $display("FAIL %s overflow: actual %0b expected %0b", req, ovf_out, exp[DW]);
        end
    endtask

    function automatic logic [DW-1:0] all_nines();
        logic [DW-1:0] v;
        for (int i = 0; i < NDIG; i++) v[4*i +: 4] = 4'd9;
        return v;
    endfunction

    function automatic logic [DW-1:0] rand_digits();
        logic [DW-1:0] v;
        for (int i = 0; i < NDIG; i++) v[4*i +: 4] = 4'($urandom_range(9));
        return v;
    endfunction

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0]   a;
        logic [NDIG-1:0] d;
        logic [DW-1:0]   lower_ref;

        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (bcd_out !== '0 || ovf_out !== 1'b0) begin
            errors++;
            $display("FAIL R2 reset state: actual %h/%0b expected 0/0", bcd_out, ovf_out);
        end
        rst_n = 1'b1;

        apply_and_check('0, '0, "R1 zero");

        // R7: full-length ripple through nines
        apply_and_check(all_nines(), NDIG'(1), "R7 nines plus bottom bit");

        // R3: nines with no carry stay nines
        apply_and_check(all_nines(), '0, "R3 nines alone");

        // R5: a column of 8 stops the chain at position 16
        a = all_nines();
        a[4*16 +: 4] = 4'd8;
        apply_and_check(a, NDIG'(1), "R5 chain killed");

        // R4: generate at position 5 within a sea of nines
        d = '0;
        d[5] = 1'b1;
        apply_and_check(all_nines(), d, "R4 generate mid");

        // R4: every column generates
        apply_and_check(all_nines(), '1, "R4 all generate");

        // R6: top column generate only
        a = '0;
        a[DW-1 -: 4] = 4'd9;
        d = '0;
        d[NDIG-1] = 1'b1;
        apply_and_check(a, d, "R6 top generate");

        // R2: bit at bottom alone, no carry from below
        apply_and_check('0, NDIG'(1), "R2 bottom bit");

        // R8 R1: random patterns
        for (int k = 0; k < 300; k++) begin
            apply_and_check(rand_digits(), NDIG'($urandom), "R1 R8 random");
        end

        // R3: random nine-runs with sparse bits
        for (int k = 0; k < 50; k++) begin
            a = all_nines();
            a[4*$urandom_range(NDIG-1) +: 4] = 4'($urandom_range(9));
            d = '0;
            d[$urandom_range(NDIG-1)] = 1'b1;
            apply_and_check(a, d, "R3 nine runs");
        end

        // R9: altering the top column keeps lower digits
        for (int k = 0; k < 20; k++) begin
            a = rand_digits();
            d = NDIG'($urandom);
            apply_and_check(a, d, "R9 base");
            lower_ref = bcd_out;
            a[DW-1 -: 4] = 4'($urandom_range(9));
            d[NDIG-1] = ~d[NDIG-1];
            apply_and_check(a, d, "R9 altered");
            checks++;
            if (bcd_out[DW-5:0] !== lower_ref[DW-5:0]) begin
                errors++;
                $display("FAIL R9 lower digits: actual %h expected %h", bcd_out[DW-5:0], lower_ref[DW-5:0]);
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule